// File: doc/BRIEF.md
# Cell Reassembly FIFO with Selectable Start Modes

This block is the receive-side buffer between a physical-layer cell interface and a downstream cell processor. Cells are a fixed number of 32-bit words. They are written one word per accepted beat, and each cell is kept in its own slot in a ring of slots. The downstream side waits for `cell_avail`, then pulls the cell word by word with `rd_en`. When `full_cell_mode` is low the block runs cut-through: a cell may be started once its first two words are stored. When it is high the block runs store-and-forward, and a cell is offered only when all of its words are stored.

Two physical-interface modes differ in how a framing sync error is handled. In the standard mode a word flagged with a sync error is stored like any other word. In the alternate mode (`alt_phy` high) the whole cell in progress is discarded by moving the write word index back to the first word of the current slot. A cut-through start could not be taken back after such a discard, so the alternate mode always forces store-and-forward behaviour. When the FIFO has no free slot at the first word of a new cell, that whole cell is dropped and a counter advances. With `loop_en` high, the transmit-side word stream replaces the receive input, and this works in both physical modes.

Top module: `cell_reasm_fifo`

## Requirements
- R1: After reset, `cell_avail` and `rd_valid` are 0 and `drop_cnt` is 0.
- R2: With `full_cell_mode`=0 and `alt_phy`=0, `cell_avail` is 0 after the first word of a cell is accepted into an empty FIFO, and 1 from the cycle after the second word is accepted.
- R3: With `full_cell_mode`=1, `cell_avail` stays 0 until the 14th (last) word of a cell is accepted, and is 1 in the cycle after that.
- R4: With `alt_phy`=1, the block behaves as in R3 whatever the value of `full_cell_mode`.
- R5: With `alt_phy`=1 and `loop_en`=0, an accepted word with `rx_sync_err`=1 is not stored. The whole cell in progress is discarded, including when the error comes on the last word, and the next accepted word becomes word 0 of a new cell. The discarded cell never raises `cell_avail` or `rd_valid`.
- R6: With `alt_phy`=0, a word that carries `rx_sync_err`=1 is stored and the cell completes normally with unchanged data.
- R7: The downstream side reads a cell in arrival order. Each `rd_en` while `rd_valid`=1 advances one word. `rd_last`=1 on word index 13. Reading the last word frees the slot, and cells leave in the order they arrived.
- R8: When 4 complete cells are held and no slot is free, an arriving cell is dropped entirely and `drop_cnt` increments by one, leaving the held cells unchanged. Once a cell is read out, the next arriving cell is accepted.
- R9: With `loop_en`=1, `tx_valid`/`tx_data` feed the FIFO and the receive inputs, including `rx_sync_err`, are ignored. With `loop_en`=0, the transmit inputs are ignored. This holds in both physical modes.
- R10: In cut-through operation, `rd_valid` is 0 when the reader has consumed every word written so far, and `cell_avail` is 0 while a cell is partly read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_cell_mode | input | 1 | 1 = store-and-forward start, 0 = cut-through start |
| alt_phy | input | 1 | 1 = alternate interface mode with cell discard on sync error |
| loop_en | input | 1 | 1 = transmit stream looped into the FIFO input |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_sync_err | input | 1 | Framing sync error flag for the current receive word |
| tx_valid | input | 1 | Transmit word valid (used in loopback) |
| tx_data | input | 32 | Transmit word (used in loopback) |
| rd_en | input | 1 | Downstream word pop |
| cell_avail | output | 1 | A cell may be started now |
| rd_valid | output | 1 | `rd_data` holds a readable word |
| rd_data | output | 32 | Word at the read position |
| rd_last | output | 1 | Read position is the last word of a cell |
| drop_cnt | output | 8 | Count of cells dropped for lack of space (wraps) |

## Verification
A table of single-cell patterns covers every combination that matters: cut-through against store-and-forward, standard against alternate interface mode, a sync error placed mid-cell or on the last word or absent, and the loopback path with garbage on the unused input. Sampling `cell_avail` after words 1, 2, 13 and 14 separates the two start modes and shows that the alternate mode overrides the start-mode bit. Reading the cell back separates a kept cell from a discarded one. Directed sequences fill all four slots to force a whole-cell drop, let the reader catch up with the writer in cut-through, and confirm that a clean cell after a discard is stored from its first word.

// File: rtl/cell_reasm_fifo.sv
module cell_reasm_fifo #(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int CELLS      = 4,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_cell_mode,
  input  logic              alt_phy,
  input  logic              loop_en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_sync_err,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rd_en,
  output logic              cell_avail,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_last,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam int WW    = (CELL_WORDS > 2) ? $clog2(CELL_WORDS) : 2;
  localparam int SW    = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int OW    = $clog2(CELLS + 1);
  localparam int DEPTH = CELLS * CELL_WORDS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [WW-1:0] LASTW = WW'(CELL_WORDS - 1);
  localparam logic [SW-1:0] LASTS = SW'(CELLS - 1);
  localparam logic [OW-1:0] FULLO = OW'(CELLS);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WW-1:0] wword, rword;
  logic [SW-1:0] wslot, rslot;
  logic [OW-1:0] occ;
  logic          dropping;

  function automatic logic [AW-1:0] loc(input logic [SW-1:0] s, input logic [WW-1:0] w);
    return AW'(s) * AW'(CELL_WORDS) + AW'(w);
  endfunction

  wire              in_v     = loop_en ? tx_valid : rx_valid;
  wire [WORD_W-1:0] in_d     = loop_en ? tx_data  : rx_data;
  wire              full_eff = full_cell_mode | alt_phy;
  wire              rewind   = in_v && !loop_en && rx_sync_err && alt_phy;
  wire              start_dr = in_v && !rewind && !dropping && wword == '0 && occ == FULLO;
  wire              wr_en    = in_v && !rewind && !dropping && !start_dr;
  wire              commit   = wr_en && wword == LASTW;
  wire              rd_fire  = rd_en && rd_valid;
  wire              release_c = rd_fire && rword == LASTW;

  assign rd_valid   = (occ != '0) || (!full_eff && !dropping && rword < wword);
  assign rd_data    = mem[loc(rslot, rword)];
  assign rd_last    = rword == LASTW;
  assign cell_avail = (rword == '0) &&
                      ((occ != '0) || (!full_eff && !dropping && wword >= WW'(2)));

  always_ff @(posedge clk)
    if (wr_en) mem[loc(wslot, wword)] <= in_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wword    <= '0;
      wslot    <= '0;
      dropping <= 1'b0;
      drop_cnt <= '0;
    end else if (rewind) begin
      wword    <= '0;
      dropping <= 1'b0;
    end else if (in_v) begin
      wword <= (wword == LASTW) ? '0 : wword + 1'b1;
      if (start_dr) begin
        drop_cnt <= drop_cnt + DROP_W'(1);
        dropping <= (CELL_WORDS > 1);
      end else if (dropping && wword == LASTW) begin
        dropping <= 1'b0;
      end
      if (commit) wslot <= (wslot == LASTS) ? '0 : wslot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rword <= '0;
      rslot <= '0;
    end else if (rd_fire) begin
      rword <= (rword == LASTW) ? '0 : rword + 1'b1;
      if (release_c) rslot <= (rslot == LASTS) ? '0 : rslot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + OW'(commit) - OW'(release_c);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(!rst_n) && !rst_n |=> !cell_avail && drop_cnt == '0); // R1
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) occ <= FULLO); // R8
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n) start_dr |=> drop_cnt == $past(drop_cnt) + DROP_W'(1)); // R8
  AST_FULL_START: assert property (@(posedge clk) disable iff (!rst_n) cell_avail && full_eff |-> occ != '0); // R4
  AST_REWIND_HOME: assert property (@(posedge clk) disable iff (!rst_n) rewind |=> wword == '0 && $stable(wslot)); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n) rd_fire && !rd_last |=> rword == $past(rword) + 1'b1); // R7
  AST_NO_OUTRUN: assert property (@(posedge clk) disable iff (!rst_n) rd_fire && occ == '0 |-> rword < wword && !full_eff); // R10

endmodule

// File: tb/cell_reasm_fifo_tb.sv
module cell_reasm_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic full_cell_mode = 0, alt_phy = 0, loop_en = 0;
  logic rx_valid = 0, rx_sync_err = 0, tx_valid = 0, rd_en = 0;
  logic [31:0] rx_data = '0, tx_data = '0;
  logic cell_avail, rd_valid, rd_last;
  logic [31:0] rd_data;
  logic [7:0] drop_cnt;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_reasm_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .full_cell_mode(full_cell_mode), .alt_phy(alt_phy),
    .loop_en(loop_en), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sync_err(rx_sync_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .rd_en(rd_en), .cell_avail(cell_avail),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .drop_cnt(drop_cnt));

  // [11] full, [10] alt, [9] loop, [8:5] error word (15 = none), [3:0] avail after words 1,2,13,14
  localparam logic [11:0] VEC [0:7] = '{
    12'b0_0_0_1111_0_0111,  // R2 cut-through
    12'b1_0_0_1111_0_0001,  // R3 store-and-forward
    12'b0_1_0_1111_0_0001,  // R4 alternate forces full cell
    12'b1_1_0_0101_0_0000,  // R5 mid-cell discard
    12'b0_1_0_1101_0_0000,  // R5 last-word discard
    12'b0_0_0_0101_0_0111,  // R6 error kept
    12'b0_0_1_1111_0_0111,  // R9 loopback standard
    12'b1_1_1_0011_0_0001   // R9 loopback alternate, rx error ignored
  };

  function automatic string vtag(input int v);
    case (v)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3, 4: return "R5";
      5: return "R6"; default: return "R9";
    endcase
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put(input logic [31:0] d, input logic err, input logic lp);
    @(negedge clk);
    rx_valid = 1; tx_valid = 1; rx_sync_err = err;
    if (lp) begin tx_data = d; rx_data = 32'hDEAD_0000 ^ d; end
    else    begin rx_data = d; tx_data = 32'hBEEF_0000 ^ d; end
    @(posedge clk); #1;
    rx_valid = 0; tx_valid = 0; rx_sync_err = 0;
  endtask

  task automatic read_cell(input logic [31:0] base, input string tag);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk(rd_valid === 1'b1, tag, {31'b0, rd_valid}, 32'd1);
      chk(rd_data === base + i, tag, rd_data, base + i);
      chk(rd_last === (i == 13), tag, {31'b0, rd_last}, {31'b0, i == 13});
      rd_en = 1;
      @(posedge clk); #1; rd_en = 0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(cell_avail === 0 && rd_valid === 0, "R1", {30'b0, cell_avail, rd_valid}, 32'd0);
    chk(drop_cnt === 0, "R1", {24'b0, drop_cnt}, 32'd0);

    for (int v = 0; v < 8; v++) begin
      logic [31:0] base;
      logic [3:0] ex;
      base = 32'hA000_0000 + 32'(v * 256);
      ex = VEC[v][3:0];
      do_reset();
      full_cell_mode = VEC[v][11]; alt_phy = VEC[v][10]; loop_en = VEC[v][9];
      for (int i = 0; i < 14; i++) begin
        put(base + i, VEC[v][8:5] == 4'(i), loop_en);
        if (i == 0)  chk(cell_avail === ex[3], vtag(v), {31'b0, cell_avail}, {31'b0, ex[3]});
        if (i == 1)  chk(cell_avail === ex[2], vtag(v), {31'b0, cell_avail}, {31'b0, ex[2]});
        if (i == 12) chk(cell_avail === ex[1], vtag(v), {31'b0, cell_avail}, {31'b0, ex[1]});
        if (i == 13) chk(cell_avail === ex[0], vtag(v), {31'b0, cell_avail}, {31'b0, ex[0]});
      end
      if (ex[0]) read_cell(base, vtag(v));
      else begin
        @(negedge clk);
        chk(rd_valid === 0, vtag(v), {31'b0, rd_valid}, 32'd0);
      end
    end
    loop_en = 0;

    // R8: four cells fill every slot, the fifth is dropped whole
    do_reset();
    full_cell_mode = 1; alt_phy = 0;
    for (int c = 0; c < 5; c++)
      for (int i = 0; i < 14; i++) put(32'hC000_0000 + 32'(c * 16 + i), 1'b0, 1'b0);
    @(negedge clk);
    chk(drop_cnt === 8'd1, "R8", {24'b0, drop_cnt}, 32'd1);
    chk(cell_avail === 1, "R8", {31'b0, cell_avail}, 32'd1);
    read_cell(32'hC000_0000, "R8");
    for (int i = 0; i < 14; i++) put(32'hC000_0050 + i, 1'b0, 1'b0);
    @(negedge clk);
    chk(drop_cnt === 8'd1, "R8", {24'b0, drop_cnt}, 32'd1);
    read_cell(32'hC000_0010, "R7");
    read_cell(32'hC000_0020, "R7");
    read_cell(32'hC000_0030, "R7");
    read_cell(32'hC000_0050, "R8");
    @(negedge clk);
    chk(rd_valid === 0 && cell_avail === 0, "R7", {30'b0, rd_valid, cell_avail}, 32'd0);

    // R10: reader catches up with the writer in cut-through
    do_reset();
    full_cell_mode = 0; alt_phy = 0;
    put(32'hE000_0000, 1'b0, 1'b0);
    put(32'hE000_0001, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); rd_en = 1; @(posedge clk); #1; rd_en = 0;
    end
    @(negedge clk);
    chk(rd_valid === 0, "R10", {31'b0, rd_valid}, 32'd0);
    chk(cell_avail === 0, "R10", {31'b0, cell_avail}, 32'd0);
    put(32'hE000_0002, 1'b0, 1'b0);
    @(negedge clk);
    chk(rd_valid === 1 && rd_data === 32'hE000_0002, "R10", rd_data, 32'hE000_0002);

    // R5: clean cell after an alternate-mode discard starts at word 0
    do_reset();
    full_cell_mode = 0; alt_phy = 1;
    for (int i = 0; i < 4; i++) put(32'hF000_0000 + i, i == 3, 1'b0);
    for (int i = 0; i < 14; i++) put(32'hF100_0000 + i, 1'b0, 1'b0);
    @(negedge clk);
    chk(cell_avail === 1, "R5", {31'b0, cell_avail}, 32'd1);
    read_cell(32'hF100_0000, "R5");

    report();
  end
endmodule